// File: doc/BRIEF.md
# I2C-Addressed Register Bank with SPI Frame Launcher

This block is an I2C target that sits on a two-wire management bus and exposes eight byte-wide registers. A master first writes a register index. It then either writes further bytes to that register, or issues a repeated start and reads that register back. The target's 7-bit bus address is a fixed five-bit prefix followed by two board-strap inputs. Several boards can therefore share one bus.

Two of the registers hold the upper half of a control word. Writing the launch code to the command register sends those sixteen bits out through a four-wire SPI port. The SPI port is mode 0 and sends the most significant bit first. The last byte shifted in from the downstream device is kept in a read-only register. A busy flag in the command register tells software when the frame has finished. A read-only version register identifies the block.

Top module: `i2c_spi_regbank`

## Requirements
- R1: The target acknowledges only the 7-bit address {5'b01111, ga[1:0]}. A transaction to any other address gets no acknowledge, and its bytes change no register.
- R2: The first byte after an acknowledged write address becomes the register pointer. Every later byte in that transaction is written to the register the pointer selects, and the pointer is not incremented.
- R3: A read-addressed transaction, including one after a repeated start, returns the register the pointer selects. Each further byte the master acknowledges returns that same register. A pointer of 8 or more reads as 0x00.
- R4: Register 0x03 always reads the VERSION parameter, and writes to it are ignored.
- R5: Register 0x07 holds control-word bits 31:24 and register 0x06 holds bits 23:16. Both read back the value last written.
- R6: Writing 0x04 to register 0x00 starts one SPI frame. In that frame spi_cs_n goes low and spi_sclk gives 16 pulses, idling low. MOSI changes only while SCLK is low and carries {reg 0x07, reg 0x06} MSB first. Any other value written to register 0x00 starts nothing.
- R7: The last 8 bits sampled from MISO at SCLK rising edges are stored in register 0x04, in arrival order with the last bit at bit 0. This register is read-only.
- R8: Bit 0 of register 0x00 reads 1 while a frame is in progress and 0 otherwise, and its other bits read 0. A launch write during a frame is ignored.
- R9: After reset, SDA is released, spi_cs_n is high, spi_sclk is low and the writable registers read 0x00.
- R10: The target changes its SDA drive only while SCL is low, and after a master not-acknowledge it leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ga | input | 2 | Board-strap bits forming the low address bits |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the downstream device |
| spi_miso | input | 1 | SPI data from the downstream device |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bit counter and the pointer are hidden. A bit counter that is off by one shows up within a single byte time, as an acknowledge on the wrong clock or a read byte shifted by one position. A stale or incremented pointer shows up in the next read data byte. A wrong launch decode or busy state shows up at spi_cs_n within one system clock of the write's acknowledge, or as an extra or missing frame. A wrong shift register shows up in the captured MOSI word or in the read-back byte once the frame ends.

// File: rtl/regbank_pkg.sv
// Package: shared constants and state type for the I2C register bank.
// Assumes an 8-entry register space addressed by the low bits of the pointer.
package regbank_pkg;
    localparam int          NUM_REGS     = 8;
    localparam int          REG_CMD      = 0;
    localparam int          REG_VERSION  = 3;
    localparam int          REG_READBACK = 4;
    localparam int          REG_CW_MID   = 6;
    localparam int          REG_CW_HI    = 7;
    localparam logic [7:0]  LAUNCH_CODE  = 8'h04;
    localparam logic [4:0]  ADDR_PREFIX  = 5'b01111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR,
        ST_ACK_W,
        ST_RD,
        ST_MACK
    } i2c_state_t;
endpackage

// File: rtl/i2c_line_mon.sv
// Module: i2c_line_mon
// Brings SCL and SDA into the clock domain through a flip-flop chain and
// reports SCL edges plus start/stop conditions (SDA edges while SCL is high).
// Assumes the system clock is well above the bus bit rate.
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    // Synchronizer chains and one-cycle history of the synchronized lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
// Module: i2c_target_fsm
// Byte-level I2C target: matches the address, holds the register pointer,
// issues a write strobe for data bytes and serializes read data.
// Assumes clean edge/condition pulses from i2c_line_mon.
module i2c_target_fsm
    import regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] ga,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    i2c_state_t st;
    logic [2:0] cnt;
    logic [7:0] sh, tx;
    logic       got8, first, rnw, mack;

    // Protocol sequencing; SDA drive only changes on SCL falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; got8 <= 1'b0;
            first <= 1'b1; rnw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
            ptr <= '0; wr_en <= 1'b0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st <= ST_ADDR; cnt <= '0; got8 <= 1'b0; first <= 1'b1; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE; sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise && !got8) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            cnt  <= '0;
                            if (st == ST_ADDR) begin
                                if (sh[7:1] == {ADDR_PREFIX, ga}) begin
                                    sda_oe <= 1'b1; rnw <= sh[0]; st <= ST_ACK_A;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= ST_ACK_W;
                                if (first) begin
                                    ptr   <= sh;
                                    first <= 1'b0;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_data <= sh;
                                end
                            end
                        end
                    end
                    ST_ACK_A: if (scl_fall) begin
                        if (rnw) begin
                            tx <= rd_data; sda_oe <= ~rd_data[7]; st <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0; st <= ST_WR;
                        end
                    end
                    ST_ACK_W: if (scl_fall) begin
                        sda_oe <= 1'b0; st <= ST_WR;
                    end
                    ST_RD: if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0; cnt <= '0; st <= ST_MACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 3'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        else if (scl_fall) begin
                            if (mack) begin
                                tx <= rd_data; sda_oe <= ~rd_data[7]; st <= ST_RD;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_launcher.sv
// Module: spi_launcher
// Mode-0 SPI master that sends one FRAME_BITS word MSB first on a go pulse
// and keeps the last RX_BITS bits sampled on SCLK rising edges.
// Assumes go is ignored by the caller's logic or here while busy.
module spi_launcher #(
    parameter int HALF_DIV   = 4,
    parameter int FRAME_BITS = 16,
    parameter int RX_BITS    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n,
    output logic                  busy,
    output logic [RX_BITS-1:0]    rx
);
    localparam int DW = $clog2(HALF_DIV + 1);
    localparam int BW = $clog2(FRAME_BITS);

    logic [DW-1:0]         div;
    logic [BW-1:0]         bitn;
    logic [FRAME_BITS-1:0] sh;
    logic [RX_BITS-1:0]    rxsh;

    // Frame timing: half-period divider, bit counter and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div <= '0; bitn <= '0; sh <= '0; rxsh <= '0; rx <= '0;
            sclk <= 1'b0; cs_n <= 1'b1; busy <= 1'b0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1; cs_n <= 1'b0; sh <= word; div <= '0; bitn <= '0;
            end
        end else if (div == DW'(HALF_DIV - 1)) begin
            div <= '0;
            if (!sclk) begin
                sclk <= 1'b1;
                rxsh <= {rxsh[RX_BITS-2:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bitn == BW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0; cs_n <= 1'b1; rx <= rxsh;
                end else begin
                    bitn <= bitn + 1'b1;
                    sh   <= {sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end else begin
            div <= div + 1'b1;
        end
    end

    // Serial output is the head of the shift register during a frame.
    always_comb mosi = busy & sh[FRAME_BITS-1];
endmodule

// File: rtl/i2c_spi_regbank.sv
// Module: i2c_spi_regbank (top)
// I2C-addressed register bank: scratch control-word bytes, a version register,
// a status/command register that launches an SPI frame, and a read-back byte.
// Assumes an external pull-up on SDA; sda_oe=1 pulls the line low.
module i2c_spi_regbank
    import regbank_pkg::*;
#(
    parameter logic [7:0] VERSION      = 8'h21,
    parameter int         SPI_HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] ga,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int IDXW = $clog2(NUM_REGS);

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, wr_data, rd_data, rx_byte;
    logic       wr_en, spi_busy, launch;
    logic [7:0] reg_view [NUM_REGS];

    i2c_line_mon #(.SYNC_STAGES(2)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .ga(ga), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    // Register slots: fixed-function entries or plain writable storage.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == REG_CMD) begin : g_cmd
            assign reg_view[g] = {7'd0, spi_busy};
        end else if (g == REG_VERSION) begin : g_ver
            assign reg_view[g] = VERSION;
        end else if (g == REG_READBACK) begin : g_rb
            assign reg_view[g] = rx_byte;
        end else begin : g_rw
            logic [7:0] q;
            // Storage for a writable byte.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else if (wr_en && ptr == 8'(g)) q <= wr_data;
            end
            assign reg_view[g] = q;
        end
    end

    // Read mux and launch decode.
    always_comb begin
        rd_data = (ptr < 8'(NUM_REGS)) ? reg_view[ptr[IDXW-1:0]] : 8'h00;
        launch  = wr_en && (ptr == 8'(REG_CMD)) && (wr_data == LAUNCH_CODE) && !spi_busy;
    end

    spi_launcher #(.HALF_DIV(SPI_HALF_DIV), .FRAME_BITS(16), .RX_BITS(8)) u_spi (
        .clk(clk), .rst_n(rst_n), .go(launch),
        .word({reg_view[REG_CW_HI], reg_view[REG_CW_MID]}),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .busy(spi_busy), .rx(rx_byte)
    );
endmodule

// File: rtl/regbank_checks.sv
// Module: regbank_checks
// Port-level protocol properties for i2c_spi_regbank, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module regbank_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    logic [5:0] pulses;
    logic       cs_q, sclk_q;

    // Counts SCLK rising edges inside one chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses <= '0; cs_q <= 1'b1; sclk_q <= 1'b0;
        end else begin
            cs_q   <= spi_cs_n;
            sclk_q <= spi_sclk;
            if (cs_q && !spi_cs_n)       pulses <= '0;
            else if (!sclk_q && spi_sclk) pulses <= pulses + 6'd1;
        end
    end

    a_r6_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    a_r6_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    a_r6_sixteen_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> pulses == 6'd16);

    a_r10_sda_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_spi_regbank regbank_checks u_checks (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/test_i2c_spi_regbank.sv
// Bench: bus-level I2C master and SPI device models with a behavioural
// register model; every read and frame is compared against the model.
module test_i2c_spi_regbank;
    localparam logic [7:0] VER  = 8'h5C;
    localparam int         HALF = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, spi_sclk, spi_mosi, spi_cs_n, spi_miso;
    logic [1:0] ga = 2'b10;
    wire  sda_line = sda_m & ~sda_oe;

    logic [15:0] miso_pat = 16'h0000;
    logic [15:0] mosi_got = 16'h0000;
    int frames = 0, nrise = 16;
    int checks = 0, failures = 0;
    logic [7:0] mdl [8];

    always #5 clk = ~clk;

    i2c_spi_regbank #(.VERSION(VER), .SPI_HALF_DIV(200)) i_i2c_spi_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .ga(ga), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Downstream SPI device: counts frames, captures MOSI, serves MISO.
    always @(negedge spi_cs_n or posedge spi_sclk) begin
        if (!spi_sclk) begin
            frames++; nrise = 0; mosi_got = 16'h0;
        end else begin
            mosi_got = {mosi_got[14:0], spi_mosi}; nrise++;
        end
    end
    assign spi_miso = (nrise < 16) ? miso_pat[15 - nrise] : 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hw(HALF); scl_m = 1'b1; hw(HALF);
        sda_m = 1'b0; hw(HALF); scl_m = 1'b0; hw(2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hw(HALF); scl_m = 1'b1; hw(HALF); sda_m = 1'b1; hw(HALF);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(HALF); scl_m = 1'b1; hw(HALF); scl_m = 1'b0; hw(2);
        end
        sda_m = 1'b1; hw(HALF); scl_m = 1'b1; hw(HALF / 2);
        ack = ~sda_line; hw(HALF / 2); scl_m = 1'b0; hw(2);
    endtask

    task automatic rbyte(input logic last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(HALF); scl_m = 1'b1; hw(HALF / 2); b[i] = sda_line;
            hw(HALF / 2); scl_m = 1'b0; hw(2);
        end
        sda_m = last; hw(HALF); scl_m = 1'b1; hw(HALF); scl_m = 1'b0; hw(2);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] g, input logic rd);
        return {5'b01111, g, rd};
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, output logic ack);
        logic k1, k2, k3;
        i2c_start(); wbyte(addr_byte(ga, 1'b0), k1); wbyte(a, k2); wbyte(d, k3); i2c_stop();
        ack = k1 & k2 & k3;
        if (k1 && a < 8 && a != 0 && a != 3 && a != 4) mdl[a[2:0]] = d;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output logic ack);
        logic k1, k2, k3;
        i2c_start(); wbyte(addr_byte(ga, 1'b0), k1); wbyte(a, k2);
        i2c_start(); wbyte(addr_byte(ga, 1'b1), k3); rbyte(1'b1, d); i2c_stop();
        ack = k1 & k2 & k3;
    endtask

    task automatic wait_frame_end();
        for (int i = 0; i < 20000 && !spi_cs_n; i++) hw(1);
        hw(10);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d, d2;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        hw(5); rst_n = 1'b1; hw(5);

        // R9 reset state
        check("R9 sda released", {15'd0, sda_oe}, 16'd0);
        check("R9 cs_n high", {15'd0, spi_cs_n}, 16'd1);
        check("R9 sclk low", {15'd0, spi_sclk}, 16'd0);
        reg_read(8'h06, d, ack);
        check("R9 reg6 zero", {8'd0, d}, {8'd0, mdl[6]});

        // R1 address match, R4 version
        reg_read(8'h03, d, ack);
        check("R1 ack own address", {15'd0, ack}, 16'd1);
        check("R4 version read", {8'd0, d}, {8'd0, VER});

        // R2/R5 control-word bytes
        reg_write(8'h06, 8'hA5, ack);
        check("R2 write acked", {15'd0, ack}, 16'd1);
        reg_write(8'h07, 8'h3C, ack);
        reg_read(8'h06, d, ack);
        check("R5 reg6 readback", {8'd0, d}, {8'd0, mdl[6]});
        reg_read(8'h07, d, ack);
        check("R5 reg7 readback", {8'd0, d}, {8'd0, mdl[7]});

        // R4 write to version ignored
        reg_write(8'h03, 8'hFF, ack);
        reg_read(8'h03, d, ack);
        check("R4 version unchanged", {8'd0, d}, {8'd0, VER});

        // R1 foreign address: no ack, no effect
        i2c_start(); wbyte(addr_byte(2'b00, 1'b0), ack);
        check("R1 foreign address nack", {15'd0, ack}, 16'd0);
        wbyte(8'h06, ack); wbyte(8'h11, ack); i2c_stop();
        reg_read(8'h06, d, ack);
        check("R1 foreign write ignored", {8'd0, d}, {8'd0, mdl[6]});

        // R3 out-of-range pointer and repeated reads without increment
        reg_read(8'h20, d, ack);
        check("R3 high pointer reads zero", {8'd0, d}, 16'h0000);
        i2c_start(); wbyte(addr_byte(ga, 1'b0), ack); wbyte(8'h07, ack);
        i2c_start(); wbyte(addr_byte(ga, 1'b1), ack);
        rbyte(1'b0, d); rbyte(1'b1, d2); i2c_stop();
        check("R3 first read byte", {8'd0, d}, {8'd0, mdl[7]});
        check("R3 second read byte same reg", {8'd0, d2}, {8'd0, mdl[7]});
        check("R10 sda released after nack", {15'd0, sda_oe}, 16'd0);

        // R6 non-launch value to command register
        reg_write(8'h00, 8'h05, ack);
        hw(100);
        check("R6 no frame on other code", frames[15:0], 16'd0);

        // R6/R7/R8 launch, busy, ignored relaunch
        miso_pat = 16'hC35A;
        reg_write(8'h00, 8'h04, ack);
        reg_read(8'h00, d, ack);
        check("R8 busy during frame", {8'd0, d}, 16'h0001);
        reg_write(8'h00, 8'h04, ack);
        wait_frame_end();
        check("R8 relaunch ignored", frames[15:0], 16'd1);
        check("R6 mosi word", mosi_got, {mdl[7], mdl[6]});
        reg_read(8'h00, d, ack);
        check("R8 idle after frame", {8'd0, d}, 16'h0000);
        reg_read(8'h04, d, ack);
        check("R7 readback byte", {8'd0, d}, {8'd0, miso_pat[7:0]});
        reg_write(8'h04, 8'h11, ack);
        reg_read(8'h04, d, ack);
        check("R7 readback read-only", {8'd0, d}, {8'd0, miso_pat[7:0]});

        // R6 second frame with new control bytes
        reg_write(8'h06, 8'h81, ack);
        reg_write(8'h07, 8'h7E, ack);
        miso_pat = 16'h0F96;
        reg_write(8'h00, 8'h04, ack);
        wait_frame_end();
        check("R6 second frame count", frames[15:0], 16'd2);
        check("R6 second mosi word", mosi_got, {mdl[7], mdl[6]});
        reg_read(8'h04, d, ack);
        check("R7 second readback", {8'd0, d}, {8'd0, miso_pat[7:0]});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule